// File: doc/BRIEF.md
# Queued SPI Master Sequencer

This block is an SPI master that works through a list of transfers held in a small on-chip queue. It needs no processor involvement once the list has been started. Each queue slot holds a command byte, a word to transmit and a word received. The command byte carries a chip-select pattern and a flag that asks for that pattern to stay asserted after the transfer ends. Software fills the slots through a simple write port and sets the start pointer and the last pointer. It then pulses a start input. The sequencer fetches each slot in turn and shifts its word out on MOSI while it captures MISO. It stores the captured word back into the same slot.

After each transfer the index of the slot just finished is recorded in a completed-pointer register, and the working pointer moves on. Writing a new start pointer while the queue is running redirects execution after the current transfer. When the slot equal to the last pointer has been executed, a done flag is raised and an interrupt request can follow. The sequencer then stops, or it restarts at slot 0 if wraparound is enabled. The serial clock comes from a modulus counter, and all four combinations of clock polarity and phase are supported.

Top module: `qsm_top`

## Requirements
- R1: A pulse on `run_set` while idle starts execution at the slot last written through `newqp_wr`/`newqp`.
- R2: Each slot's transmit word goes out on MOSI most significant bit first. The word captured on MISO during that transfer can afterwards be read from the same slot index through `rx_raddr`/`rx_rdata`.
- R3: When a transfer completes, `done_ptr` takes the index of that slot and execution continues at the next index (modulo 16).
- R4: A pointer write through `newqp_wr` during a transfer lets that transfer finish normally. The next transfer is then taken from the written slot and not from the incremented one.
- R5: Command byte layout: bit 7 is the hold flag and bits 3..0 are the chip-select pattern on `sel`. With the hold flag set, `sel` keeps that slot's pattern through the gap after the transfer. A different pattern from the following slot appears only when that slot's shifting starts, and `sel` stays constant while a word is shifting.
- R6: With the hold flag clear, `sel` shows `idle_sel` between transfers. It also shows `idle_sel` whenever the sequencer is stopped.
- R7: Completing the slot equal to `endqp` sets `done_flag`. `irq` equals `done_flag` when `irq_en` is 1 and is 0 otherwise. `done_clr` clears the flag.
- R8: After the `endqp` slot, the sequencer stops (`busy` low) if `wrap_en` is 0, and continues at slot 0 if `wrap_en` is 1. A `run_clr` pulse stops it after the transfer in progress.
- R9: SCK rests at `cpol` whenever no word is shifting. With `cpha`=0, MISO is sampled on the first (leading) edge of each bit and MOSI changes on the trailing edge. With `cpha`=1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R10: Each SCK half period lasts `baud` system clocks, which gives SCK = f_clk/(2*baud). Values 0 and 1 act as 2.
- R11: After reset `busy`, `done_flag`, `irq` and `done_ptr` are 0, SCK equals `cpol` and `sel` equals `idle_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| q_wr | input | 1 | Write strobe for a queue slot |
| q_waddr | input | 4 | Slot index written |
| q_wcmd | input | 8 | Command byte (bit 7 hold, bits 3..0 select pattern) |
| q_wtx | input | 8 | Transmit word for the slot |
| rx_raddr | input | 4 | Slot index for reading a received word |
| rx_rdata | output | 8 | Received word at `rx_raddr` |
| run_set | input | 1 | Start pulse |
| run_clr | input | 1 | Stop after the current transfer |
| newqp_wr | input | 1 | Strobe for the new start pointer |
| newqp | input | 4 | New start pointer value |
| endqp | input | 4 | Index of the last slot |
| wrap_en | input | 1 | Restart at slot 0 after the last slot |
| irq_en | input | 1 | Interrupt enable |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | Clock phase select |
| baud | input | 8 | Half-period divisor |
| idle_sel | input | 4 | Select pattern driven between unheld transfers |
| done_clr | input | 1 | Clears the done flag |
| busy | output | 1 | Sequencer executing |
| done_ptr | output | 4 | Index of the last completed slot |
| done_flag | output | 1 | Last slot reached |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel | output | 4 | Chip-select pattern |

## Verification
The assertions assume that `cpol`, `cpha` and `baud` stay constant while `busy` is high, and that `run_set` is pulsed only while the sequencer is idle. The park check on SCK and the half-period gap check depend on this. The stimulus changes the mode and the divisor only between runs, with the slave model disarmed while it does so. It writes the new pointer mid-run only inside the first transfer, and it issues the stop pulse only while a transfer is shifting.

// File: rtl/qsm_pkg.sv
package qsm_pkg;
  localparam int DIVW = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_FIN} qsm_st_t;

  // half-period length in system clocks; values below 2 are clamped
  function automatic logic [DIVW-1:0] eff_div(input logic [DIVW-1:0] d);
    return (d < DIVW'(2)) ? DIVW'(2) : d;
  endfunction
endpackage

// File: rtl/qsm_baud.sv
module qsm_baud
  import qsm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt;
  logic [DIVW-1:0] lim;

  assign lim  = eff_div(div) - DIVW'(1);
  assign tick = active && (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!active || tick) cnt <= '0;
    else                      cnt <= cnt + DIVW'(1);
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R10
endmodule

// File: rtl/qsm_shift.sv
module qsm_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] tx_in,
  input  logic          tick,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          miso,
  output logic          sck,
  output logic          mosi,
  output logic          last,
  output logic [DW-1:0] rx_word
);
  localparam int HALVES = 2 * DW;
  localparam int HW     = $clog2(HALVES);

  logic [DW-1:0] tx_sh, rx_sh;
  logic [HW-1:0] h;
  logic          sck_q, xfer;
  logic          smp, adv;

  // leading edges have even h, trailing edges odd h
  assign smp  = cpha ? h[0] : !h[0];
  assign adv  = cpha ? (!h[0] && (h != '0)) : h[0];
  assign last = tick && xfer && (h == HW'(HALVES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0; rx_sh <= '0; h <= '0; sck_q <= 1'b0; xfer <= 1'b0;
    end else if (load) begin
      tx_sh <= tx_in; h <= '0; sck_q <= cpol; xfer <= 1'b1;
    end else if (tick && xfer) begin
      sck_q <= ~sck_q;
      h     <= h + HW'(1);
      if (smp)  rx_sh <= {rx_sh[DW-2:0], miso};
      if (adv)  tx_sh <= {tx_sh[DW-2:0], 1'b0};
      if (last) xfer  <= 1'b0;
    end
  end

  assign sck     = xfer ? sck_q : cpol;
  assign mosi    = tx_sh[DW-1];
  assign rx_word = rx_sh;

  AST_SCK_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer) |-> (sck_q == cpol)); // R9
endmodule

// File: rtl/qsm_top.sv
module qsm_top
  import qsm_pkg::*;
#(
  parameter int QD  = 16,
  parameter int DW  = 8,
  parameter int CSW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   q_wr,
  input  logic [$clog2(QD)-1:0]  q_waddr,
  input  logic [7:0]             q_wcmd,
  input  logic [DW-1:0]          q_wtx,
  input  logic [$clog2(QD)-1:0]  rx_raddr,
  output logic [DW-1:0]          rx_rdata,
  input  logic                   run_set,
  input  logic                   run_clr,
  input  logic                   newqp_wr,
  input  logic [$clog2(QD)-1:0]  newqp,
  input  logic [$clog2(QD)-1:0]  endqp,
  input  logic                   wrap_en,
  input  logic                   irq_en,
  input  logic                   cpol,
  input  logic                   cpha,
  input  logic [7:0]             baud,
  input  logic [CSW-1:0]         idle_sel,
  input  logic                   done_clr,
  output logic                   busy,
  output logic [$clog2(QD)-1:0]  done_ptr,
  output logic                   done_flag,
  output logic                   irq,
  output logic                   sck,
  output logic                   mosi,
  input  logic                   miso,
  output logic [CSW-1:0]         sel
);
  localparam int PW      = $clog2(QD);
  localparam int HOLDBIT = 7;

  logic [7:0]    cmd_mem [QD];
  logic [DW-1:0] tx_mem  [QD];
  logic [DW-1:0] rx_mem  [QD];

  qsm_st_t       st;
  logic          run, pend, cont_q;
  logic [PW-1:0] wp, nq, nxt;
  logic [CSW-1:0] cs_q;
  logic [DW-1:0] rx_word;

  // named internal events
  logic go, fin, at_end, stop_now, tick, last;
  assign go       = (st == ST_IDLE) && run_set;
  assign fin      = (st == ST_FIN);
  assign at_end   = (wp == endqp);
  assign stop_now = (at_end && !wrap_en) || !run || run_clr;
  assign nxt      = pend ? nq : (at_end ? '0 : wp + PW'(1));

  qsm_baud u_baud (
    .clk(clk), .rst_n(rst_n), .active(st == ST_SHIFT), .div(baud), .tick(tick)
  );

  qsm_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(st == ST_LOAD), .tx_in(tx_mem[wp]),
    .tick(tick), .cpol(cpol), .cpha(cpha), .miso(miso),
    .sck(sck), .mosi(mosi), .last(last), .rx_word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (q_wr) begin
      cmd_mem[q_waddr] <= q_wcmd;
      tx_mem[q_waddr]  <= q_wtx;
    end
    if (fin) rx_mem[wp] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; run <= 1'b0; pend <= 1'b0; cont_q <= 1'b0;
      wp <= '0; nq <= '0; done_ptr <= '0; done_flag <= 1'b0; cs_q <= '0;
    end else begin
      if (done_clr) done_flag <= 1'b0;
      unique case (st)
        ST_IDLE: if (run_set) begin
          run <= 1'b1; wp <= nq; pend <= 1'b0; st <= ST_LOAD;
        end
        ST_LOAD: begin
          cs_q   <= cmd_mem[wp][CSW-1:0];
          cont_q <= cmd_mem[wp][HOLDBIT];
          st     <= ST_SHIFT;
        end
        ST_SHIFT: if (last) st <= ST_FIN;
        ST_FIN: begin
          done_ptr <= wp;
          if (at_end) done_flag <= 1'b1;
          wp   <= nxt;
          pend <= 1'b0;
          if (stop_now) begin
            run <= 1'b0; cont_q <= 1'b0; st <= ST_IDLE;
          end else begin
            st <= ST_LOAD;
          end
        end
        default: st <= ST_IDLE;
      endcase
      if (run_clr && st != ST_IDLE) run <= 1'b0;
      if (newqp_wr) begin
        nq   <= newqp;
        pend <= (st != ST_IDLE);
      end
    end
  end

  assign busy     = (st != ST_IDLE);
  assign irq      = done_flag && irq_en;
  assign sel      = ((st == ST_SHIFT) || cont_q) ? cs_q : idle_sel;
  assign rx_rdata = rx_mem[rx_raddr];

  AST_GO_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (wp == $past(nq))); // R1
  AST_DONE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (done_ptr == $past(wp))); // R3
  AST_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && pend && !stop_now && !newqp_wr) |=> (wp == $past(nq))); // R4
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SHIFT && $past(st) == ST_SHIFT) |-> $stable(sel)); // R5
  AST_DONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(fin && at_end)); // R7
  AST_END_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && at_end && !wrap_en) |=> (st == ST_IDLE)); // R8
  AST_IDLE_SCK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (sck == cpol)); // R9
endmodule

// File: tb/qsm_top_test.sv
module qsm_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic q_wr = 0; logic [3:0] q_waddr = 0; logic [7:0] q_wcmd = 0; logic [7:0] q_wtx = 0;
  logic [3:0] rx_raddr = 0; logic [7:0] rx_rdata;
  logic run_set = 0, run_clr = 0, newqp_wr = 0; logic [3:0] newqp = 0, endqp = 0;
  logic wrap_en = 0, irq_en = 0, cpol = 0, cpha = 0; logic [7:0] baud = 8'd2;
  logic [3:0] idle_sel = 4'hF; logic done_clr = 0;
  logic busy, done_flag, irq, sck, mosi; logic miso = 1'b0;
  logic [3:0] done_ptr, sel;

  int checks = 0, failures = 0;
  logic [7:0] txm [16];
  logic [7:0] sl_src [32];
  logic [7:0] sl_got [32];
  int sl_n, sl_k, sl_cnt; logic [7:0] sl_sh, sl_rx; logic sl_arm = 1'b0;
  logic [3:0] cs_log [16]; int cs_n; logic cs_mon = 1'b0;
  int ord [8];

  always #10 clk = ~clk;

  qsm_top uut (.*);

  function automatic int exp_half(input logic [7:0] b);
    return (b < 2) ? 2 : int'(b);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model: reacts to SCK edges per cpol/cpha
  always @(sck) if (sl_arm) begin
    if (sck != cpol) begin : lead
      if (!cpha) begin
        sl_rx = {sl_rx[6:0], mosi}; sl_cnt++;
        if (sl_cnt == 8) begin sl_got[sl_n] = sl_rx; sl_n++; end
      end else if (sl_cnt != 0) sl_sh = sl_sh << 1;
    end else begin : trail
      if (!cpha) begin
        if (sl_cnt == 8) begin sl_cnt = 0; sl_k++; sl_sh = sl_src[sl_k]; end
        else sl_sh = sl_sh << 1;
      end else begin
        sl_rx = {sl_rx[6:0], mosi}; sl_cnt++;
        if (sl_cnt == 8) begin
          sl_got[sl_n] = sl_rx; sl_n++; sl_cnt = 0; sl_k++; sl_sh = sl_src[sl_k];
        end
      end
    end
    miso = sl_sh[7];
  end

  always @(negedge clk) if (cs_mon && sel != cs_log[cs_n-1] && cs_n < 16) begin
    cs_log[cs_n] = sel; cs_n++;
  end

  task automatic slave_prep();
    sl_arm = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 32; i++) sl_src[i] = 8'($urandom);
    sl_n = 0; sl_k = 0; sl_cnt = 0; sl_rx = 0; sl_sh = sl_src[0]; miso = sl_sh[7];
    sl_arm = 1'b1;
  endtask

  task automatic put(input int idx, input logic [7:0] cmd, input logic [7:0] tx);
    @(negedge clk); q_wr = 1; q_waddr = 4'(idx); q_wcmd = cmd; q_wtx = tx; txm[idx] = tx;
    @(negedge clk); q_wr = 0;
  endtask

  task automatic set_ptr(input int p);
    @(negedge clk); newqp_wr = 1; newqp = 4'(p);
    @(negedge clk); newqp_wr = 0;
  endtask

  task automatic pulse_go();
    @(negedge clk); run_set = 1; @(negedge clk); run_set = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clr_done();
    @(negedge clk); done_clr = 1; @(negedge clk); done_clr = 0;
  endtask

  task automatic check_ord(input string req, input int n);
    chk({req, " transfer count"}, 32'(sl_n), 32'(n));
    for (int i = 0; i < n; i++) begin
      chk({req, " word seen by slave"}, 32'(sl_got[i]), 32'(txm[ord[i]]));
      @(negedge clk); rx_raddr = 4'(ord[i]); @(negedge clk);
      chk({req, " word stored in slot"}, 32'(rx_rdata), 32'(sl_src[i]));
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", 32'(busy), 0); chk("R11 done_flag", 32'(done_flag), 0);
    chk("R11 irq", 32'(irq), 0); chk("R11 done_ptr", 32'(done_ptr), 0);
    chk("R11 sck", 32'(sck), 32'(cpol)); chk("R11 sel", 32'(sel), 32'hF);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R7 R8 R9: four modes, slots 0..3
    for (int m = 0; m < 4; m++) begin
      cpol = m[1]; cpha = m[0]; baud = 8'(2 + m); irq_en = m[0];
      for (int i = 0; i < 4; i++) begin put(i, 8'h00, 8'($urandom)); ord[i] = i; end
      endqp = 4'd3; set_ptr(0); slave_prep(); pulse_go(); wait_idle();
      check_ord("R2 R9", 4);
      chk("R3 done_ptr", 32'(done_ptr), 3);
      chk("R7 done_flag", 32'(done_flag), 1);
      chk("R7 irq", 32'(irq), 32'(irq_en));
      chk("R8 stopped", 32'(busy), 0);
      chk("R9 sck idle", 32'(sck), 32'(cpol));
      chk("R6 sel stopped", 32'(sel), 32'hF);
      clr_done();
      chk("R7 cleared", 32'(done_flag), 0);
    end
    cpol = 0; cpha = 0; irq_en = 1;

    // R10 half period, including clamp of 0 and 1
    for (int j = 0; j < 4; j++) begin
      int t, t1, t2, nchg; logic prev;
      baud = (j == 0) ? 8'd0 : (j == 1) ? 8'd1 : (j == 2) ? 8'd3 : 8'd7;
      put(0, 8'h00, 8'($urandom)); endqp = 4'd0; set_ptr(0); slave_prep();
      t = 0; nchg = 0; t1 = 0; t2 = 0; prev = sck;
      pulse_go();
      while (busy && nchg < 2) begin
        @(negedge clk); t++;
        if (sck != prev) begin nchg++; if (nchg == 1) t1 = t; else t2 = t; end
        prev = sck;
      end
      chk("R10 half period", 32'(t2 - t1), 32'(exp_half(baud)));
      wait_idle(); clr_done();
    end
    baud = 8'd2;

    // R1 start pointer
    for (int i = 4; i < 10; i++) put(i, 8'h00, 8'($urandom));
    ord[0] = 5; ord[1] = 6; ord[2] = 7;
    endqp = 4'd7; set_ptr(5); slave_prep(); pulse_go(); wait_idle();
    check_ord("R1", 3);
    chk("R1 done_ptr", 32'(done_ptr), 7);
    clr_done();

    // R4 redirect during first transfer
    ord[0] = 0; ord[1] = 8; ord[2] = 9;
    endqp = 4'd9; set_ptr(0); slave_prep(); pulse_go();
    repeat (6) @(negedge clk);
    set_ptr(8);
    wait_idle();
    check_ord("R4", 3);
    chk("R4 done_ptr", 32'(done_ptr), 9);
    clr_done();

    // R8 wraparound and stop request
    put(14, 8'h00, 8'($urandom)); put(15, 8'h00, 8'($urandom));
    ord[0] = 14; ord[1] = 15; ord[2] = 0;
    wrap_en = 1; endqp = 4'd15; set_ptr(14); slave_prep(); pulse_go();
    while (sl_n < 3) @(negedge clk);
    chk("R8 wrap still busy", 32'(busy), 1);
    chk("R8 done set on wrap", 32'(done_flag), 1);
    chk("R8 wrapped to slot 0", 32'(sl_got[2]), 32'(txm[0]));
    repeat (3) @(negedge clk);
    @(negedge clk); run_clr = 1; @(negedge clk); run_clr = 0;
    wait_idle();
    chk("R8 stop request", 32'(busy), 0);
    chk("R8 one more transfer", 32'(sl_n), 4);
    wrap_en = 0; clr_done();

    // R5 R6 select hold
    put(10, 8'h8E, 8'($urandom)); put(11, 8'h0D, 8'($urandom)); put(12, 8'h8B, 8'($urandom));
    endqp = 4'd12; set_ptr(10); slave_prep();
    cs_log[0] = sel; cs_n = 1; cs_mon = 1'b1;
    pulse_go(); wait_idle(); cs_mon = 1'b0;
    chk("R5 R6 sel change count", 32'(cs_n), 6);
    chk("R6 sel before first", 32'(cs_log[0]), 32'hF);
    chk("R5 sel slot 10", 32'(cs_log[1]), 32'hE);
    chk("R5 sel slot 11 held gap", 32'(cs_log[2]), 32'hD);
    chk("R6 sel unheld gap", 32'(cs_log[3]), 32'hF);
    chk("R5 sel slot 12", 32'(cs_log[4]), 32'hB);
    chk("R6 sel after stop", 32'(cs_log[5]), 32'hF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule